// File: doc/BRIEF.md
# Linear-Page Translation Cache with Replayed Invalidation

The block keeps recent translations from linear page numbers to physical frames. It is direct-indexed: the low bits of the page number choose one of the entries, and the remaining bits are stored as a tag. Each entry holds a frame number and two permissions, one for reads and one for writes. A page walker outside the block fills entries. The core asks for a page through the lookup port and gets hit, frame and the two permissions back in the same cycle.

Every fill is also recorded in a side list of page numbers. Invalidation then replays only that list and clears one recorded entry per clock. It never sweeps the whole array. A full invalidation starts when the directory base is rewritten while paging is on, or when the paging-enable input changes. It also starts by itself when a fill finds the list already full. In that case the fill waits, the flush runs, and the waiting entry is inserted as the first entry of the new list.

A read-only fill grants reads and withholds writes, so a later write to that page misses and returns to the walker. An unlink command clears a run of consecutive entries and leaves the list unchanged.

Top module: `xlat_cache`

## Requirements
- R1: A lookup hits when the indexed entry's tag equals the upper page bits and the entry grants the requested access: reads need read permission and writes (lk_write=1) need write permission. The frame output then carries the stored frame, and rd_ok/wr_ok report the entry's permissions for the matching tag.
- R2: A normal fill (fill_ro=0) writes tag and frame and grants both permissions at the entry selected by fill_page[7:0]. It appends the page to the link list, which grows by one.
- R3: A read-only fill (fill_ro=1) grants read permission only. Reads of that page hit and writes miss. Write permission is never granted without read permission.
- R4: While busy is high, every lookup misses with rd_ok=wr_ok=0, and fills, unlinks and directory-base strobes are ignored.
- R5: A directory-base strobe while paging_en=1 starts a full flush. busy stays high for (list length + 1) cycles, every listed entry loses both permissions, and the list becomes empty.
- R6: A directory-base strobe while paging_en=0 has no effect: busy stays low and all entries keep hitting.
- R7: Any change of paging_en starts a full flush with the same timing as R5. Driving paging_en to the value it already has does nothing.
- R8: A fill that arrives when the list holds 64 pages first runs a full flush of (64 + 1) busy cycles. It then inserts the new entry, so afterwards only that page hits and the list holds one page.
- R9: A fill of the same page as the most recently recorded one replaces that list slot instead of appending, so repeated refills of one page never grow the list.
- R10: An unlink with start index S and length N clears both permissions of entries S, S+1, ... S+N-1, modulo 256. The list is unchanged, so a later flush still takes (list length + 1) cycles.
- R11: After reset every lookup misses and busy is low.
- R12: A page whose index matches a stored entry but whose tag differs misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Paging enable level; a change starts a flush |
| dir_base_we | input | 1 | Directory-base write strobe |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_page | input | 20 | Linear page number looked up |
| fill_valid | input | 1 | Fill request from the walker |
| fill_ro | input | 1 | Fill grants read permission only |
| fill_page | input | 20 | Linear page number being filled |
| fill_frame | input | 20 | Physical frame for the fill |
| unlink_valid | input | 1 | Unlink request |
| unlink_idx | input | 8 | First entry index to clear (low page bits) |
| unlink_len | input | 9 | Number of consecutive entries to clear (0 to 256) |
| hit | output | 1 | Lookup hit for the requested access |
| frame | output | 20 | Frame of the indexed entry |
| rd_ok | output | 1 | Indexed entry matches and grants reads |
| wr_ok | output | 1 | Indexed entry matches and grants writes |
| busy | output | 1 | Flush in progress |

## Verification
The checker watches, on every cycle, the rules that are local in time. Lookups stay dead while busy. A write grant always comes with a read grant. The list never exceeds its capacity and grows by exactly one on each append. Every flush begin raises busy, and every flush end leaves the list empty or holding only the waiting fill. Whole-array content is left to the bench's sweeps over all 256 indices against a reference model: which entries survive a flush, a wrapped unlink or an aliasing refill. The same applies to the exact flush length, the way refills of one page hold back overflow, and that strobes issued while paging is off or while busy change nothing.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // distance from start to pos going upward around a ring of size mask+1
  function automatic int unsigned ring_dist(int unsigned pos, int unsigned start,
                                            int unsigned mask);
    return (pos - start) & mask;
  endfunction

  // true when pos lies in the window [start, start+len) on the ring
  function automatic logic in_window(int unsigned pos, int unsigned start,
                                     int unsigned len, int unsigned mask);
    return ring_dist(pos, start, mask) < len;
  endfunction

endpackage

// File: rtl/xc_entry_array.sv
module xc_entry_array #(
  parameter int IDX_W   = 8,
  parameter int TAG_W   = 12,
  parameter int FRAME_W = 20,
  parameter int UNL_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_ro,
  input  logic               clr_one_en,
  input  logic [IDX_W-1:0]   clr_one_idx,
  input  logic               clr_rng_en,
  input  logic [IDX_W-1:0]   clr_rng_start,
  input  logic [UNL_W-1:0]   clr_rng_len,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [TAG_W-1:0]   lk_tag,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_rd,
  output logic               lk_wr
);
  import xc_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] rd_q;
  logic [ENTRIES-1:0] wr_q;

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= fill_tag;
      frame_q[fill_idx] <= fill_frame;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_perm
    logic sel_fill;
    logic sel_clr;
    assign sel_fill = fill_en && (fill_idx == IDX_W'(g));
    assign sel_clr  = (clr_one_en && (clr_one_idx == IDX_W'(g))) ||
                      (clr_rng_en && in_window(32'(g), 32'(clr_rng_start),
                                               32'(clr_rng_len), 32'(ENTRIES - 1)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_q[g] <= 1'b0;
        wr_q[g] <= 1'b0;
      end else if (sel_fill) begin
        rd_q[g] <= 1'b1;
        wr_q[g] <= !fill_ro;
      end else if (sel_clr) begin
        rd_q[g] <= 1'b0;
        wr_q[g] <= 1'b0;
      end
    end
  end

  assign lk_tag   = tag_q[lk_idx];
  assign lk_frame = frame_q[lk_idx];
  assign lk_rd    = rd_q[lk_idx];
  assign lk_wr    = wr_q[lk_idx];

endmodule

// File: rtl/xc_link_list.sv
module xc_link_list #(
  parameter int PAGE_W = 20,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [PAGE_W-1:0] push_page,
  input  logic              clear_en,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [PAGE_W-1:0] last_page,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  logic [PAGE_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] rd_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_en) begin
      cnt_q <= push_en ? CNT_W'(1) : '0;
    end else if (push_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      if (clear_en) slot_q[0] <= push_page;
      else          slot_q[PTR_W'(cnt_q)] <= push_page;
    end
  end

  assign rd_page   = slot_q[rd_ptr];
  assign rd_idx    = rd_page[IDX_W-1:0];
  assign last_page = slot_q[PTR_W'(cnt_q - CNT_W'(1))];
  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/xc_flush_seq.sv
module xc_flush_seq #(
  parameter int CNT_W = 7,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             step,
  output logic             done,
  output logic [PTR_W-1:0] ptr
);
  import xc_pkg::*;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cursor_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cursor_q <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q  <= SEQ_RUN;
            cursor_q <= '0;
          end
        end
        SEQ_RUN: begin
          if (cursor_q == count) state_q <= SEQ_IDLE;
          else                   cursor_q <= cursor_q + CNT_W'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SEQ_RUN);
  assign done = busy && (cursor_q == count);
  assign step = busy && !done;
  assign ptr  = cursor_q[PTR_W-1:0];

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int PAGE_W     = 20,
  parameter int FRAME_W    = 20,
  parameter int IDX_W      = 8,
  parameter int LIST_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               paging_en,
  input  logic               dir_base_we,
  input  logic               lk_valid,
  input  logic               lk_write,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic               fill_valid,
  input  logic               fill_ro,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               unlink_valid,
  input  logic [IDX_W-1:0]   unlink_idx,
  input  logic [IDX_W:0]     unlink_len,
  output logic               hit,
  output logic [FRAME_W-1:0] frame,
  output logic               rd_ok,
  output logic               wr_ok,
  output logic               busy
);

  localparam int TAG_W = PAGE_W - IDX_W;
  localparam int CNT_W = $clog2(LIST_DEPTH + 1);
  localparam int PTR_W = $clog2(LIST_DEPTH);
  localparam int UNL_W = IDX_W + 1;

  // named internal events, watched by the checker
  logic ev_push;
  logic ev_flush_start;
  logic ev_flush_done;
  logic ev_overflow;

  logic              en_q;
  logic              pend_vld;
  logic [PAGE_W-1:0] pend_page;
  logic [FRAME_W-1:0] pend_frame;
  logic              pend_ro;

  logic              seq_step;
  logic [PTR_W-1:0]  seq_ptr;
  logic [IDX_W-1:0]  list_rd_idx;
  logic [PAGE_W-1:0] list_last;
  logic [CNT_W-1:0]  link_count;
  logic              list_full;

  logic idle, flush_req, do_unlink, fill_go, pop_hit, direct_fill, late_fill;
  logic               arr_fill_en;
  logic [PAGE_W-1:0]  arr_fill_page;
  logic [FRAME_W-1:0] arr_fill_frame;
  logic               arr_fill_ro;

  logic [TAG_W-1:0]   e_tag;
  logic [FRAME_W-1:0] e_frame;
  logic               e_rd, e_wr, tag_eq;

  // command arbitration: flush triggers, then unlink, then fill
  assign idle        = !busy;
  assign flush_req   = idle && ((dir_base_we && paging_en) || (paging_en != en_q));
  assign do_unlink   = idle && !flush_req && unlink_valid;
  assign fill_go     = idle && !flush_req && !unlink_valid && fill_valid;
  assign pop_hit     = fill_go && (link_count != '0) && (list_last == fill_page);
  assign ev_overflow = fill_go && !pop_hit && list_full;
  assign direct_fill = fill_go && !ev_overflow;
  assign late_fill   = ev_flush_done && pend_vld;

  assign ev_flush_start = flush_req || ev_overflow;
  assign ev_push        = (direct_fill && !pop_hit) || late_fill;

  assign arr_fill_en    = direct_fill || late_fill;
  assign arr_fill_page  = late_fill ? pend_page  : fill_page;
  assign arr_fill_frame = late_fill ? pend_frame : fill_frame;
  assign arr_fill_ro    = late_fill ? pend_ro    : fill_ro;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pend_vld <= 1'b0;
    end else begin
      if (idle) en_q <= paging_en;
      if (ev_overflow)        pend_vld <= 1'b1;
      else if (ev_flush_done) pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_overflow) begin
      pend_page  <= fill_page;
      pend_frame <= fill_frame;
      pend_ro    <= fill_ro;
    end
  end

  xc_flush_seq #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_flush_start),
    .count (link_count),
    .busy  (busy),
    .step  (seq_step),
    .done  (ev_flush_done),
    .ptr   (seq_ptr)
  );

  xc_link_list #(
    .PAGE_W(PAGE_W), .IDX_W(IDX_W), .DEPTH(LIST_DEPTH),
    .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_list (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (ev_push),
    .push_page (arr_fill_page),
    .clear_en  (ev_flush_done),
    .rd_ptr    (seq_ptr),
    .rd_idx    (list_rd_idx),
    .last_page (list_last),
    .count     (link_count),
    .full      (list_full)
  );

  xc_entry_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .FRAME_W(FRAME_W), .UNL_W(UNL_W)
  ) u_arr (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_en       (arr_fill_en),
    .fill_idx      (arr_fill_page[IDX_W-1:0]),
    .fill_tag      (arr_fill_page[PAGE_W-1:IDX_W]),
    .fill_frame    (arr_fill_frame),
    .fill_ro       (arr_fill_ro),
    .clr_one_en    (seq_step),
    .clr_one_idx   (list_rd_idx),
    .clr_rng_en    (do_unlink),
    .clr_rng_start (unlink_idx),
    .clr_rng_len   (unlink_len),
    .lk_idx        (lk_page[IDX_W-1:0]),
    .lk_tag        (e_tag),
    .lk_frame      (e_frame),
    .lk_rd         (e_rd),
    .lk_wr         (e_wr)
  );

  assign tag_eq = (e_tag == lk_page[PAGE_W-1:IDX_W]);
  assign rd_ok  = idle && tag_eq && e_rd;
  assign wr_ok  = idle && tag_eq && e_wr;
  assign hit    = lk_valid && (lk_write ? wr_ok : rd_ok);
  assign frame  = e_frame;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             hit,
  input logic             rd_ok,
  input logic             wr_ok,
  input logic [CNT_W-1:0] link_count,
  input logic             pend_vld,
  input logic             ev_push,
  input logic             ev_flush_start,
  input logic             ev_flush_done,
  input logic             ev_overflow
);

  assert_miss_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!hit && !rd_ok && !wr_ok));

  assert_write_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> rd_ok);

  assert_list_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_count <= CNT_W'(DEPTH));

  assert_overflow_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |-> (link_count == CNT_W'(DEPTH)));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_flush_done) |=> (link_count == $past(link_count) + CNT_W'(1)));

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_done |=> (link_count == ($past(pend_vld) ? CNT_W'(1) : CNT_W'(0))));

  assert_start_raises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush_start |=> busy);

endmodule

bind xlat_cache xlat_cache_chk #(.DEPTH(LIST_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .hit            (hit),
  .rd_ok          (rd_ok),
  .wr_ok          (wr_ok),
  .link_count     (link_count),
  .pend_vld       (pend_vld),
  .ev_push        (ev_push),
  .ev_flush_start (ev_flush_start),
  .ev_flush_done  (ev_flush_done),
  .ev_overflow    (ev_overflow)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

  localparam int NENT  = 256;
  localparam int NLIST = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en = 1'b0;
  logic        dir_base_we = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_write = 1'b0;
  logic [19:0] lk_page = '0;
  logic        fill_valid = 1'b0;
  logic        fill_ro = 1'b0;
  logic [19:0] fill_page = '0;
  logic [19:0] fill_frame = '0;
  logic        unlink_valid = 1'b0;
  logic [7:0]  unlink_idx = '0;
  logic [8:0]  unlink_len = '0;
  logic        hit, rd_ok, wr_ok, busy;
  logic [19:0] frame;

  always #4 clk = ~clk;  // 125 MHz

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base_we(dir_base_we),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_page(lk_page),
    .fill_valid(fill_valid), .fill_ro(fill_ro), .fill_page(fill_page),
    .fill_frame(fill_frame), .unlink_valid(unlink_valid), .unlink_idx(unlink_idx),
    .unlink_len(unlink_len), .hit(hit), .frame(frame), .rd_ok(rd_ok),
    .wr_ok(wr_ok), .busy(busy)
  );

  int total = 0;
  int fails = 0;

  // reference model
  bit m_rd [NENT];
  bit m_wr [NENT];
  int m_tag [NENT];
  int m_frm [NENT];
  int m_list [NLIST];
  int m_cnt = 0;

  function automatic int frm_of(int page);
    return (page * 13 + 5) & 32'hFFFFF;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_flush();
    for (int k = 0; k < m_cnt; k++) begin
      m_rd[m_list[k] & 255] = 0;
      m_wr[m_list[k] & 255] = 0;
    end
    m_cnt = 0;
  endtask

  task automatic m_write(int page, bit ro);
    m_rd[page & 255]  = 1;
    m_wr[page & 255]  = !ro;
    m_tag[page & 255] = page >> 8;
    m_frm[page & 255] = frm_of(page);
  endtask

  // counts busy cycles after a command edge
  task automatic measure_busy(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (busy) n++;
      else break;
      if (n > 2000) break;
    end
  endtask

  task automatic do_fill(int page, bit ro, string req);
    int n;
    bit ovf;
    bit pop;
    pop = (m_cnt > 0) && (m_list[m_cnt-1] == page);
    ovf = !pop && (m_cnt == NLIST);
    @(negedge clk);
    fill_valid = 1'b1; fill_ro = ro; fill_page = 20'(page); fill_frame = 20'(frm_of(page));
    @(posedge clk);
    #1 fill_valid = 1'b0;
    measure_busy(n);
    if (ovf) begin
      chk(n == NLIST + 1, "R8", "overflow flush length", n, NLIST + 1);
      m_flush();
      m_write(page, ro);
      m_list[0] = page; m_cnt = 1;
    end else begin
      chk(n == 0, req, "fill raised busy", n, 0);
      m_write(page, ro);
      if (!pop) begin m_list[m_cnt] = page; m_cnt++; end
    end
  endtask

  task automatic dir_strobe(int exp_len, string req);
    int n;
    @(negedge clk);
    dir_base_we = 1'b1;
    @(posedge clk);
    #1 dir_base_we = 1'b0;
    measure_busy(n);
    chk(n == exp_len, req, "busy cycles after directory strobe", n, exp_len);
    if (exp_len > 0) m_flush();
  endtask

  task automatic set_enable(bit v, string req);
    int n;
    int exp;
    exp = (v != paging_en) ? m_cnt + 1 : 0;
    @(negedge clk);
    paging_en = v;
    @(posedge clk);
    #1;
    measure_busy(n);
    chk(n == exp, req, "busy cycles after enable write", n, exp);
    if (exp > 0) m_flush();
  endtask

  task automatic do_unlink(int start, int len);
    @(negedge clk);
    unlink_valid = 1'b1; unlink_idx = 8'(start); unlink_len = 9'(len);
    @(posedge clk);
    #1 unlink_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      m_rd[(start + k) & 255] = 0;
      m_wr[(start + k) & 255] = 0;
    end
  endtask

  task automatic lookup(int page, bit w, output bit h);
    @(negedge clk);
    lk_valid = 1'b1; lk_write = w; lk_page = 20'(page);
    #1 h = hit;
    lk_valid = 1'b0;
  endtask

  // sweep every index, read and write, against the model
  task automatic check_all(string req);
    for (int i = 0; i < NENT; i++) begin
      int page;
      page = (m_tag[i] << 8) | i;
      @(negedge clk);
      lk_valid = 1'b1; lk_page = 20'(page);
      for (int w = 0; w < 2; w++) begin
        bit eh;
        lk_write = w[0];
        #1;
        eh = w[0] ? m_wr[i] : m_rd[i];
        chk(hit == eh, req, $sformatf("hit page %0h write %0d", page, w), hit, eh);
        if (w == 0) begin
          chk(rd_ok == m_rd[i], req, "rd_ok", rd_ok, m_rd[i]);
          chk(wr_ok == m_wr[i], req, "wr_ok", wr_ok, m_wr[i]);
        end
        if (eh) chk(frame == 20'(m_frm[i]), req, "frame", frame, m_frm[i]);
      end
      lk_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit h;
    int n;
    for (int i = 0; i < NENT; i++) begin m_rd[i] = 0; m_wr[i] = 0; m_tag[i] = 0; m_frm[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
    check_all("R11");

    set_enable(1'b1, "R7");
    set_enable(1'b1, "R7");

    // normal and read-only fills across many indices and tags
    for (int k = 0; k < 40; k++) do_fill((k * 7 + 1) * 256 / 4 + k * 3 + 2, (k % 3) == 0, "R2");
    check_all("R1");
    check_all("R3");

    // aliasing on index 5
    do_fill(20'h00105, 1'b0, "R2");
    do_fill(20'h00205, 1'b0, "R2");
    lookup(20'h00105, 1'b0, h);
    chk(h == 1'b0, "R12", "old tag on shared index", h, 0);
    lookup(20'h00205, 1'b0, h);
    chk(h == 1'b1, "R12", "new tag on shared index", h, 1);

    // wrapped unlink, list untouched
    for (int k = 0; k < 12; k++) do_fill(20'h07000 + 245 + k, 1'b0, "R2");
    do_unlink(250, 10);
    check_all("R10");
    dir_strobe(m_cnt + 1, "R10");
    check_all("R5");

    // paging off: strobe ignored, enable change flushes
    set_enable(1'b0, "R7");
    for (int k = 0; k < 9; k++) do_fill(20'h0A000 + k * 17, k[0], "R2");
    dir_strobe(0, "R6");
    check_all("R6");
    set_enable(1'b1, "R7");
    check_all("R7");

    // activity during a flush
    for (int k = 0; k < 10; k++) do_fill(20'h0C000 + k, 1'b0, "R2");
    @(negedge clk);
    dir_base_we = 1'b1;
    @(posedge clk);
    #1 dir_base_we = 1'b0;
    @(negedge clk);
    lk_valid = 1'b1; lk_write = 1'b0; lk_page = 20'h0C003;
    fill_valid = 1'b1; fill_ro = 1'b0; fill_page = 20'h0D0AA; fill_frame = 20'h12345;
    unlink_valid = 1'b0;
    #1;
    chk(busy == 1'b1, "R4", "busy during flush", busy, 1);
    chk(hit == 1'b0, "R4", "lookup during flush", hit, 0);
    @(posedge clk);
    #1 fill_valid = 1'b0; lk_valid = 1'b0;
    measure_busy(n);
    m_flush();
    lookup(20'h0D0AA, 1'b0, h);
    chk(h == 1'b0, "R4", "fill during flush ignored", h, 0);
    check_all("R4");

    // refill of latest page does not grow the list, then overflow
    for (int k = 0; k < 30; k++) do_fill(20'h0E321, 1'b0, "R9");
    for (int k = 0; k < NLIST - 1; k++) do_fill(20'h40000 + k * 37, 1'b0, "R9");
    chk(m_cnt == NLIST, "R9", "model list length", m_cnt, NLIST);
    do_fill(20'h5F0F0, 1'b1, "R8");
    check_all("R8");
    lookup(20'h5F0F0, 1'b1, h);
    chk(h == 1'b0, "R3", "write to read-only refill", h, 0);
    dir_strobe(2, "R8");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule